// File: doc/BRIEF.md
# Double-Buffered Crosspoint Switch Fabric

This block is a square, non-blocking crosspoint fabric. It has sixteen lanes in and sixteen lanes out by default. Every output lane has its own selector, which can pick any input lane. One input can feed any number of outputs at the same time. Each lane carries a data word and a valid flag. Both travel through the chosen selector and one output register.

Routing is programmed in two stages:

1. **Stage.** A controller presents a destination (output) address and a source (input) address, then pulses a load strobe. The source address is written into the staging register of that one output.
2. **Commit.** Once every change is staged, a single commit pulse copies the whole staging bank into the active select bank in one clock edge.

Outputs whose selection did not change keep their path through the commit without a gap. A combinational read-back port returns the active select of any output, so the controller can confirm that a commit took effect.

Top module: `xb_fabric`

## Requirements
- R1: While `rst` is high at a rising edge, every output lane's data and valid go to 0 on that edge. After reset, both banks hold the identity map: output n selects input n.
- R2: The outputs are registered. Output lane n in cycle t+1 carries the data and valid that were on input lane s in cycle t, where s is the active select of output n in cycle t.
- R3: A load pulse writes `prog_src` into the staging entry of output `prog_dst` only. The active routing, the read-back value and the output data do not change until a commit.
- R4: A commit pulse copies every staging entry into the active bank on the same edge. From the next cycle all changed outputs follow their new sources together.
- R5: If load and commit are high in the same cycle, the load updates staging first. The commit then transfers the updated value, so the addressed output takes `prog_src` at once.
- R6: Several outputs may hold the same active select. Each of them then carries an identical copy of that input lane.
- R7: An output whose staged select equals its active select keeps carrying the same input lane, with no missing or foreign word, across the commit edge.
- R8: `rb_sel` equals the active select of the output addressed by `rb_addr`, in the same cycle, with no clock delay.
- R9: Staged entries that are never committed leave the active bank unchanged for any number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| prog_load | input | 1 | Single-cycle strobe: stage `prog_src` for output `prog_dst` |
| prog_commit | input | 1 | Single-cycle strobe: copy all staged selects into the active bank |
| prog_dst | input | 4 | Output lane being programmed |
| prog_src | input | 4 | Input lane to be selected |
| lane_data_i | input | 128 | Input lane data; lane k occupies bits [8k+7:8k] |
| lane_vld_i | input | 16 | Input lane valid flags, bit k for lane k |
| lane_data_o | output | 128 | Output lane data; lane n occupies bits [8n+7:8n] |
| lane_vld_o | output | 16 | Output lane valid flags, bit n for lane n |
| rb_addr | input | 4 | Output lane whose active select is read back |
| rb_sel | output | 4 | Active select of output `rb_addr` |

## Verification
The hardest case to reach from the ports is a commit edge where some outputs change source while others are re-staged to the select they already hold. The outputs that keep their select must show no disturbance at exactly that edge. The bench stages a same-value entry and a real change together and fills the input lanes with fresh random words every cycle, so a wrong word on the unchanged lane would be visible in the commit cycle. A behavioural model compares every output lane every cycle. It also covers the same-cycle load-and-commit ordering, a long idle stretch with uncommitted staging, fan-out, and a random programming phase.

// File: rtl/xb_pkg.sv
package xb_pkg;

    // Default geometry of the fabric
    localparam int XB_PORTS = 16;
    localparam int XB_DW    = 8;

    // Select width needed to address a given number of lanes
    function automatic int sel_width(input int ports);
        return (ports > 1) ? $clog2(ports) : 1;
    endfunction

    // Phase of the two-step programming protocol seen on a cycle
    typedef enum logic [1:0] {
        PH_IDLE   = 2'b00,
        PH_STAGE  = 2'b01,
        PH_COMMIT = 2'b10,
        PH_BOTH   = 2'b11
    } prog_phase_t;

    function automatic prog_phase_t phase_of(input logic load, input logic commit);
        return prog_phase_t'({commit, load});
    endfunction

endpackage

// File: rtl/xb_stage_bank.sv
module xb_stage_bank #(
    parameter int NPORT = xb_pkg::XB_PORTS,
    parameter int SELW  = xb_pkg::sel_width(NPORT)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       load,
    input  logic [SELW-1:0]            dst,
    input  logic [SELW-1:0]            src,
    output logic [NPORT-1:0][SELW-1:0] stage_q,
    output logic [NPORT-1:0][SELW-1:0] stage_nx
);

    // Staging contents as they stand once this cycle's load is applied
    always_comb begin
        stage_nx = stage_q;
        if (load) begin
            stage_nx[dst] = src;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NPORT; i++) begin
                stage_q[i] <= SELW'(i);
            end
        end else begin
            stage_q <= stage_nx;
        end
    end

    AST_STAGE_WRITE: assert property (@(posedge clk) disable iff (rst)
        load |=> stage_q[$past(dst)] == $past(src)); // R3

    for (genvar g = 0; g < NPORT; g++) begin : g_keep
        AST_STAGE_KEEP: assert property (@(posedge clk) disable iff (rst)
            (!load || dst != SELW'(g)) |=> $stable(stage_q[g])); // R3
    end

endmodule

// File: rtl/xb_active_bank.sv
module xb_active_bank #(
    parameter int NPORT = xb_pkg::XB_PORTS,
    parameter int SELW  = xb_pkg::sel_width(NPORT)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       commit,
    input  logic [NPORT-1:0][SELW-1:0] stage_nx,
    output logic [NPORT-1:0][SELW-1:0] act_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NPORT; i++) begin
                act_q[i] <= SELW'(i);
            end
        end else if (commit) begin
            act_q <= stage_nx;
        end
    end

    AST_ACT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(act_q)); // R9

endmodule

// File: rtl/xb_route_lane.sv
module xb_route_lane #(
    parameter int NPORT = xb_pkg::XB_PORTS,
    parameter int DW    = xb_pkg::XB_DW,
    parameter int SELW  = xb_pkg::sel_width(NPORT)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [SELW-1:0]          sel,
    input  logic [NPORT-1:0][DW-1:0] data_all,
    input  logic [NPORT-1:0]         vld_all,
    output logic [DW-1:0]            data_o,
    output logic                     vld_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_o <= '0;
            vld_o  <= 1'b0;
        end else begin
            data_o <= data_all[sel];
            vld_o  <= vld_all[sel];
        end
    end

    AST_LANE_RESET: assert property (@(posedge clk)
        rst |=> (data_o == '0 && !vld_o)); // R1

endmodule

// File: rtl/xb_fabric.sv
module xb_fabric #(
    parameter int NPORT = xb_pkg::XB_PORTS,
    parameter int DW    = xb_pkg::XB_DW,
    localparam int SELW = xb_pkg::sel_width(NPORT)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  prog_load,
    input  logic                  prog_commit,
    input  logic [SELW-1:0]       prog_dst,
    input  logic [SELW-1:0]       prog_src,
    input  logic [NPORT*DW-1:0]   lane_data_i,
    input  logic [NPORT-1:0]      lane_vld_i,
    output logic [NPORT*DW-1:0]   lane_data_o,
    output logic [NPORT-1:0]      lane_vld_o,
    input  logic [SELW-1:0]       rb_addr,
    output logic [SELW-1:0]       rb_sel
);
    import xb_pkg::*;

    logic [NPORT-1:0][SELW-1:0] stage_sel;
    logic [NPORT-1:0][SELW-1:0] stage_next;
    logic [NPORT-1:0][SELW-1:0] act_sel;
    logic [NPORT-1:0][DW-1:0]   data_in_2d;
    prog_phase_t                phase;

    assign data_in_2d = lane_data_i;
    assign phase      = phase_of(prog_load, prog_commit);

    xb_stage_bank #(.NPORT(NPORT), .SELW(SELW)) u_stage (
        .clk      (clk),
        .rst      (rst),
        .load     (prog_load),
        .dst      (prog_dst),
        .src      (prog_src),
        .stage_q  (stage_sel),
        .stage_nx (stage_next)
    );

    xb_active_bank #(.NPORT(NPORT), .SELW(SELW)) u_active (
        .clk      (clk),
        .rst      (rst),
        .commit   (prog_commit),
        .stage_nx (stage_next),
        .act_q    (act_sel)
    );

    for (genvar n = 0; n < NPORT; n++) begin : g_lane
        xb_route_lane #(.NPORT(NPORT), .DW(DW), .SELW(SELW)) u_lane (
            .clk      (clk),
            .rst      (rst),
            .sel      (act_sel[n]),
            .data_all (data_in_2d),
            .vld_all  (lane_vld_i),
            .data_o   (lane_data_o[n*DW +: DW]),
            .vld_o    (lane_vld_o[n])
        );
    end

    assign rb_sel = act_sel[rb_addr];

    AST_COMMIT_ALL: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_COMMIT) |=> act_sel == $past(stage_sel)); // R4

    AST_SAME_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_BOTH) |=> act_sel[$past(prog_dst)] == $past(prog_src)); // R5

    AST_STAGE_ONLY: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_STAGE) |=> $stable(act_sel)); // R3

endmodule

// File: tb/xb_fabric_test.sv
module xb_fabric_test;

    localparam int CLK_PERIOD = 40;
    localparam int NP = 16;
    localparam int DW = 8;

    logic              clk = 1'b0;
    logic              rst;
    logic              prog_load, prog_commit;
    logic [3:0]        prog_dst, prog_src, rb_addr, rb_sel;
    logic [NP*DW-1:0]  lane_data_i, lane_data_o;
    logic [NP-1:0]     lane_vld_i, lane_vld_o;

    int total = 0;
    int bad   = 0;

    // behavioural reference state
    int               m_stg [NP];
    int               m_act [NP];
    logic [NP*DW-1:0] exp_data;
    logic [NP-1:0]    exp_vld;

    always #(CLK_PERIOD/2) clk = ~clk;

    xb_fabric uut (
        .clk(clk), .rst(rst), .prog_load(prog_load), .prog_commit(prog_commit),
        .prog_dst(prog_dst), .prog_src(prog_src),
        .lane_data_i(lane_data_i), .lane_vld_i(lane_vld_i),
        .lane_data_o(lane_data_o), .lane_vld_o(lane_vld_o),
        .rb_addr(rb_addr), .rb_sel(rb_sel)
    );

    // Reference: outputs from old routing, then load, then commit
    always @(posedge clk) begin
        if (rst) begin
            exp_data = '0;
            exp_vld  = '0;
            for (int i = 0; i < NP; i++) begin
                m_stg[i] = i;
                m_act[i] = i;
            end
        end else begin
            for (int n = 0; n < NP; n++) begin
                exp_data[n*DW +: DW] = lane_data_i[m_act[n]*DW +: DW];
                exp_vld[n]           = lane_vld_i[m_act[n]];
            end
            if (prog_load)   m_stg[prog_dst] = int'(prog_src);
            if (prog_commit) for (int i = 0; i < NP; i++) m_act[i] = m_stg[i];
        end
    end

    task automatic check(input string req, input bit ok, input logic [255:0] got, input logic [255:0] want);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, got, want);
        end
    endtask

    task automatic drive_lanes();
        for (int k = 0; k < NP; k++) lane_data_i[k*DW +: DW] = DW'($urandom);
        lane_vld_i = NP'($urandom);
    endtask

    // one clock: check all lanes after the edge, then clear strobes and refresh inputs
    task automatic step(input string req);
        @(posedge clk);
        #2;
        check(req, lane_data_o == exp_data && lane_vld_o == exp_vld,
              {lane_vld_o, lane_data_o}, {exp_vld, exp_data});
        prog_load   = 1'b0;
        prog_commit = 1'b0;
        drive_lanes();
    endtask

    task automatic rb_all(input string req);
        for (int k = 0; k < NP; k++) begin
            rb_addr = 4'(k);
            #1;
            check(req, rb_sel == 4'(m_act[k]), 256'(rb_sel), 256'(m_act[k]));
        end
    endtask

    task automatic stage(input int dst, input int src, input bit commit);
        prog_dst    = 4'(dst);
        prog_src    = 4'(src);
        prog_load   = 1'b1;
        prog_commit = commit;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [DW-1:0] keep0;
        rst = 1'b1; prog_load = 1'b0; prog_commit = 1'b0;
        prog_dst = '0; prog_src = '0; rb_addr = '0;
        drive_lanes();
        for (int i = 0; i < 3; i++) step("R1 reset output zero");
        rst = 1'b0;
        rb_all("R1 identity after reset");
        for (int i = 0; i < 5; i++) step("R2 identity routing");

        // staging alone: nothing moves
        stage(3, 7, 1'b0); step("R3 load only");
        stage(5, 7, 1'b0); step("R3 load only");
        rb_all("R3 active unchanged after load");
        for (int i = 0; i < 50; i++) step("R9 uncommitted idle");
        rb_all("R9 active unchanged after idle");

        // commit, then fan-out
        prog_commit = 1'b1; step("R4 commit edge");
        rb_all("R4 all staged committed");
        step("R4 new routing");
        check("R6 fan-out data", lane_data_o[3*DW +: DW] == lane_data_o[5*DW +: DW],
              256'(lane_data_o[3*DW +: DW]), 256'(lane_data_o[5*DW +: DW]));
        check("R6 fan-out valid", lane_vld_o[3] == lane_vld_o[5],
              256'(lane_vld_o[3]), 256'(lane_vld_o[5]));

        // same-value restage on lane 0, real change on lane 1
        stage(0, 0, 1'b0); step("R7 restage same");
        stage(1, 9, 1'b1);
        keep0 = lane_data_i[0 +: DW];
        step("R7 commit edge");
        check("R7 lane0 on commit edge", lane_data_o[0 +: DW] == keep0,
              256'(lane_data_o[0 +: DW]), 256'(keep0));
        keep0 = lane_data_i[0 +: DW];
        step("R7 after commit");
        check("R7 lane0 after commit", lane_data_o[0 +: DW] == keep0,
              256'(lane_data_o[0 +: DW]), 256'(keep0));

        // load and commit together
        stage(2, 11, 1'b1); step("R5 load with commit");
        rb_addr = 4'd2; #1;
        check("R5 same-cycle commit", rb_sel == 4'd11, 256'(rb_sel), 256'd11);
        step("R5 routed");

        // random programming
        for (int i = 0; i < 300; i++) begin
            if ($urandom_range(2) == 0) stage(int'($urandom_range(15)), int'($urandom_range(15)), 1'b0);
            if ($urandom_range(7) == 0) prog_commit = 1'b1;
            rb_addr = 4'($urandom_range(15)); #1;
            check("R8 readback", rb_sel == 4'(m_act[rb_addr]), 256'(rb_sel), 256'(m_act[rb_addr]));
            step("R2 random program");
        end
        rb_all("R8 final readback");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule